// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the timing skeleton of a video raster. A horizontal counter advances once per pixel clock and wraps at a programmed line length. A second counter tracks the position in the field in half-lines, so one programmed field length covers both progressive and interlace-style timing. From these two positions the block derives the current line and pixel, a top/bottom field flag, an active-video window, one-cycle pulses at the start of each field, and several independent sync output sets. Each sync set has one horizontal and one vertical sync.

Software sets up the block through a single-cycle register write port. It programs line and field lengths, an active window for each field, and for every sync set a horizontal span, vertical start and stop lines per field, and the pixel within the line at which each vertical edge takes effect. A restart write brings the counters back to the origin so that a new setup starts cleanly. In locked (slave) mode, a rising edge on an external sync input pulls the counters to the start of the top field. In master mode they run freely.

Top module: `raster_timing_gen`

## Requirements
- R1: `pix_x` counts pixel clocks from 0. The next value is 0 whenever `pix_x + 1` is greater than or equal to the line-length register (word address 1, bits 15:0); otherwise it is `pix_x + 1`.
- R2: A half-line counter advances whenever the pixel counter enters 0 or enters half the line length (line length shifted right by one, when that is nonzero). It returns to 0 after the value field length − 1, where the field length is at word address 2, bits 15:0, in half-lines. `line_y` equals half-line count / 2 + 1. `bottom_field` is high while the half-line count is at least field length / 2.
- R3: `active` is high when `line_y` and `pix_x` both lie, inclusively, within the first/last corners of the current field's window. The corners are at word addresses 4 and 5 for the top field and 6 and 7 for the bottom field, each with the line in bits 31:16 and the pixel in bits 15:0.
- R4: `top_pulse` is high exactly while the half-line count and the pixel count are both 0. `bottom_pulse` is high exactly in the first cycle of half-line field length / 2, which is pixel 0 for an even half-line and pixel line-length/2 for an odd one.
- R5: Sync set k has its registers at word address 8 + 8k + n. For n = 0, the assert pixel is in bits 15:0 and the release pixel in bits 31:16. `hsync[k]` is high for pixels in [assert, release); when assert > release the span wraps around the line end; when the two are equal the output stays low.
- R6: `vsync[k]` rises at (start line, start pixel) and falls at (stop line, stop pixel), with the stop position taking precedence. The start line is in bits 15:0 and the stop line in bits 31:16 of n = 1 (top field) or n = 2 (bottom field). The matching pixels are in bits 15:0 and 31:16 of n = 3 (top) or n = 4 (bottom). The field flag selects which pair is in force. Between the two positions the output holds its level.
- R7: A write to word address 3 with bit 0 set puts both counters at 0 and clears every vertical sync state on the following cycle. The same write with bit 0 clear has no effect.
- R8: Bit 0 of word address 0 selects master (0) or locked (1) mode. In locked mode a 0-to-1 change of `ext_sync`, seen at a clock edge, puts both counters at 0 on the next cycle. In master mode `ext_sync` has no effect.
- R9: Synchronous reset clears every register and counter, giving `pix_x` = 0, `line_y` = 1 and all sync outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register word address |
| wr_data | input | 32 | Register write data |
| ext_sync | input | 1 | External sync input for locked mode |
| pix_x | output | 16 | Current pixel position in the line |
| line_y | output | 16 | Current line number (from 1) |
| bottom_field | output | 1 | High during the bottom field |
| active | output | 1 | Inside the current field's active window |
| top_pulse | output | 1 | Start of top field |
| bottom_pulse | output | 1 | Start of bottom field |
| hsync | output | NSETS | Horizontal sync per set |
| vsync | output | NSETS | Vertical sync per set |

## Verification
The bench builds the block with its defaults: four sync sets, 16-bit position fields and a 6-bit address. It programs tiny rasters of 20-pixel and 3-pixel lines with fields of 16, 14 and 6 half-lines. Because a whole frame is then only a few hundred cycles, every pixel of several complete frames is compared against an arithmetic model. These frames include an odd half-field where the bottom field opens mid-line, wrapped and empty horizontal spans, a vertical sync that spans both fields, and relocks at arbitrary points.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

    localparam int FW         = 16;
    localparam int REG_W      = 2 * FW;
    localparam int SET_BASE   = 8;
    localparam int SET_STRIDE = 8;

    typedef logic [FW-1:0] coord_t;

    typedef struct packed {
        coord_t hi;
        coord_t lo;
    } pair_t;

    typedef struct packed {
        coord_t line;
        coord_t pix;
    } pos_t;

    typedef struct packed {
        pair_t h;
        pair_t v_top;
        pair_t v_bot;
        pair_t e_top;
        pair_t e_bot;
    } sync_cfg_t;

    typedef struct packed {
        logic   slave;
        coord_t line_len;
        coord_t field_len;
        pos_t   top_first;
        pos_t   top_last;
        pos_t   bot_first;
        pos_t   bot_last;
    } core_cfg_t;

    typedef enum logic [2:0] {
        RA_MODE      = 3'd0,
        RA_LINE_LEN  = 3'd1,
        RA_FIELD_LEN = 3'd2,
        RA_RESTART   = 3'd3,
        RA_TOP_FIRST = 3'd4,
        RA_TOP_LAST  = 3'd5,
        RA_BOT_FIRST = 3'd6,
        RA_BOT_LAST  = 3'd7
    } core_addr_e;

    typedef enum logic [2:0] {
        SA_HORZ     = 3'd0,
        SA_VTOP     = 3'd1,
        SA_VBOT     = 3'd2,
        SA_EDGE_TOP = 3'd3,
        SA_EDGE_BOT = 3'd4
    } set_addr_e;

    // Half-open span [lo, hi) that may wrap past the line end.
    function automatic logic span_on(coord_t p, coord_t lo, coord_t hi);
        if (lo < hi)
            return (p >= lo) && (p < hi);
        else if (lo > hi)
            return (p >= lo) || (p < hi);
        else
            return 1'b0;
    endfunction

    // Inclusive rectangle test.
    function automatic logic in_window(pos_t p, pos_t first, pos_t last);
        return (p.line >= first.line) && (p.line <= last.line) &&
               (p.pix  >= first.pix)  && (p.pix  <= last.pix);
    endfunction

endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
    import rtg_pkg::*;
#(
    parameter int NSETS  = 4,
    parameter int ADDR_W = 6
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [REG_W-1:0]            wr_data,
    output core_cfg_t                   core,
    output sync_cfg_t [NSETS-1:0]       sets,
    output logic                        restart
);

    localparam int SN_W = ADDR_W - 3;

    logic              core_hit;
    core_addr_e        core_idx;
    logic [ADDR_W-1:0] set_off;
    logic [SN_W-1:0]   set_num;
    set_addr_e         set_idx;

    always_comb begin
        core_hit = wr_en && (wr_addr < ADDR_W'(SET_BASE));
        core_idx = core_addr_e'(wr_addr[2:0]);
        set_off  = wr_addr - ADDR_W'(SET_BASE);
        set_num  = set_off[ADDR_W-1:3];
        set_idx  = set_addr_e'(set_off[2:0]);
        restart  = core_hit && (core_idx == RA_RESTART) && wr_data[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core <= '0;
        end else if (core_hit) begin
            case (core_idx)
                RA_MODE:      core.slave     <= wr_data[0];
                RA_LINE_LEN:  core.line_len  <= wr_data[FW-1:0];
                RA_FIELD_LEN: core.field_len <= wr_data[FW-1:0];
                RA_TOP_FIRST: core.top_first <= pos_t'(wr_data);
                RA_TOP_LAST:  core.top_last  <= pos_t'(wr_data);
                RA_BOT_FIRST: core.bot_first <= pos_t'(wr_data);
                RA_BOT_LAST:  core.bot_last  <= pos_t'(wr_data);
                default: ;
            endcase
        end
    end

    for (genvar k = 0; k < NSETS; k++) begin : g_set_regs
        sync_cfg_t cfg_q;
        logic      sel;

        assign sel     = wr_en && !core_hit && (set_num == SN_W'(k));
        assign sets[k] = cfg_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q <= '0;
            end else if (sel) begin
                case (set_idx)
                    SA_HORZ:     cfg_q.h     <= pair_t'(wr_data);
                    SA_VTOP:     cfg_q.v_top <= pair_t'(wr_data);
                    SA_VBOT:     cfg_q.v_bot <= pair_t'(wr_data);
                    SA_EDGE_TOP: cfg_q.e_top <= pair_t'(wr_data);
                    SA_EDGE_BOT: cfg_q.e_bot <= pair_t'(wr_data);
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/rtg_raster.sv
module rtg_raster
    import rtg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   restart,
    input  logic   slave,
    input  logic   ext_sync,
    input  coord_t line_len,
    input  coord_t field_len,
    output pos_t   pos,
    output logic   bottom,
    output logic   top_pulse,
    output logic   bottom_pulse
);

    coord_t      hcnt;
    coord_t      hl;
    logic        ext_q;
    logic [FW:0] h_inc;
    logic [FW:0] hl_inc;
    coord_t      h_nx;
    coord_t      hl_nx;
    coord_t      half_len;
    coord_t      half_fld;
    logic        adv;
    logic        relock;

    always_comb begin
        half_len = {1'b0, line_len[FW-1:1]};
        half_fld = {1'b0, field_len[FW-1:1]};
        h_inc    = {1'b0, hcnt} + {{FW{1'b0}}, 1'b1};
        h_nx     = (h_inc >= {1'b0, line_len}) ? '0 : h_inc[FW-1:0];
        adv      = (h_nx == '0) || ((half_len != '0) && (h_nx == half_len));
        hl_inc   = {1'b0, hl} + {{FW{1'b0}}, 1'b1};
        if (!adv)
            hl_nx = hl;
        else if (hl_inc >= {1'b0, field_len})
            hl_nx = '0;
        else
            hl_nx = hl_inc[FW-1:0];
        relock = slave && ext_sync && !ext_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt  <= '0;
            hl    <= '0;
            ext_q <= 1'b0;
        end else begin
            ext_q <= ext_sync;
            if (restart || relock) begin
                hcnt <= '0;
                hl   <= '0;
            end else begin
                hcnt <= h_nx;
                hl   <= hl_nx;
            end
        end
    end

    always_comb begin
        pos.pix      = hcnt;
        pos.line     = {1'b0, hl[FW-1:1]} + coord_t'(1);
        bottom       = (hl >= half_fld);
        top_pulse    = (hl == '0) && (hcnt == '0);
        bottom_pulse = (hl == half_fld) && ((hcnt == '0) || (hcnt == half_len));
    end

    // R1
    hwrap_chk: assert property (@(posedge clk) disable iff (rst)
        (h_inc >= {1'b0, line_len}) |=> (pos.pix == '0));

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> (pos.pix == '0) && (pos.line == coord_t'(1)) && !bottom_pulse);

    // R8
    relock_chk: assert property (@(posedge clk) disable iff (rst)
        (slave && $rose(ext_sync)) |=> (pos.pix == '0) && (pos.line == coord_t'(1)));

    // R4
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (field_len >= coord_t'(2)) |-> $onehot0({top_pulse, bottom_pulse}));

endmodule

// File: rtl/rtg_sync_set.sv
module rtg_sync_set
    import rtg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      restart,
    input  pos_t      pos,
    input  logic      bottom,
    input  sync_cfg_t cfg,
    output logic      hs,
    output logic      vs
);

    pair_t vlines;
    pair_t vpix;
    logic  start_hit;
    logic  stop_hit;
    logic  vs_q;

    always_comb begin
        vlines    = bottom ? cfg.v_bot : cfg.v_top;
        vpix      = bottom ? cfg.e_bot : cfg.e_top;
        start_hit = (pos.line == vlines.lo) && (pos.pix == vpix.lo);
        stop_hit  = (pos.line == vlines.hi) && (pos.pix == vpix.hi);
        vs        = !stop_hit && (start_hit || vs_q);
        hs        = span_on(pos.pix, cfg.h.lo, cfg.h.hi);
    end

    always_ff @(posedge clk) begin
        if (rst || restart)
            vs_q <= 1'b0;
        else
            vs_q <= vs;
    end

    // R6
    vs_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(vs_q) |-> $past(start_hit));

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int NSETS  = 4,
    parameter int ADDR_W = $clog2(SET_BASE + SET_STRIDE * NSETS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              ext_sync,
    output logic [15:0]       pix_x,
    output logic [15:0]       line_y,
    output logic              bottom_field,
    output logic              active,
    output logic              top_pulse,
    output logic              bottom_pulse,
    output logic [NSETS-1:0]  hsync,
    output logic [NSETS-1:0]  vsync
);

    core_cfg_t             core;
    sync_cfg_t [NSETS-1:0] sets;
    logic                  restart;
    pos_t                  pos;
    logic                  bottom;

    rtg_regs #(.NSETS(NSETS), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .core    (core),
        .sets    (sets),
        .restart (restart)
    );

    rtg_raster u_raster (
        .clk          (clk),
        .rst          (rst),
        .restart      (restart),
        .slave        (core.slave),
        .ext_sync     (ext_sync),
        .line_len     (core.line_len),
        .field_len    (core.field_len),
        .pos          (pos),
        .bottom       (bottom),
        .top_pulse    (top_pulse),
        .bottom_pulse (bottom_pulse)
    );

    for (genvar k = 0; k < NSETS; k++) begin : g_sync
        rtg_sync_set u_set (
            .clk     (clk),
            .rst     (rst),
            .restart (restart),
            .pos     (pos),
            .bottom  (bottom),
            .cfg     (sets[k]),
            .hs      (hsync[k]),
            .vs      (vsync[k])
        );
    end

    always_comb begin
        pix_x        = pos.pix;
        line_y       = pos.line;
        bottom_field = bottom;
        active       = bottom ? in_window(pos, core.bot_first, core.bot_last)
                              : in_window(pos, core.top_first, core.top_last);
    end

endmodule

// File: tb/raster_timing_gen_test.sv
module raster_timing_gen_test;

    localparam int NS = 4;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic          ext_sync = 1'b0;
    logic [15:0]   pix_x;
    logic [15:0]   line_y;
    logic          bottom_field;
    logic          active;
    logic          top_pulse;
    logic          bottom_pulse;
    logic [NS-1:0] hsync;
    logic [NS-1:0] vsync;

    raster_timing_gen #(.NSETS(NS), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ext_sync(ext_sync), .pix_x(pix_x), .line_y(line_y),
        .bottom_field(bottom_field), .active(active), .top_pulse(top_pulse),
        .bottom_pulse(bottom_pulse), .hsync(hsync), .vsync(vsync)
    );

    always #2 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // model state
    int          m_h, m_hl, m_len, m_fl;
    bit          m_slave, m_extq;
    logic [31:0] m_win [4];
    logic [31:0] m_set [NS][5];
    bit          m_vsq [NS];

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic bit m_bot();
        return m_hl >= (m_fl / 2);
    endfunction

    function automatic int m_line();
        return m_hl / 2 + 1;
    endfunction

    function automatic bit span(int p, int lo, int hi);
        if (lo < hi) return (p >= lo) && (p < hi);
        if (lo > hi) return (p >= lo) || (p < hi);
        return 0;
    endfunction

    function automatic bit m_hs(int k);
        return span(m_h, int'(m_set[k][0][15:0]), int'(m_set[k][0][31:16]));
    endfunction

    function automatic bit m_vs(int k);
        int iv = m_bot() ? 2 : 1;
        int ie = m_bot() ? 4 : 3;
        bit st = (m_line() == int'(m_set[k][iv][15:0]))  && (m_h == int'(m_set[k][ie][15:0]));
        bit sp = (m_line() == int'(m_set[k][iv][31:16])) && (m_h == int'(m_set[k][ie][31:16]));
        return !sp && (st || m_vsq[k]);
    endfunction

    function automatic bit m_active();
        int f = m_bot() ? 2 : 0;
        logic [31:0] a = m_win[f];
        logic [31:0] b = m_win[f + 1];
        return (m_line() >= int'(a[31:16])) && (m_line() <= int'(b[31:16])) &&
               (m_h >= int'(a[15:0])) && (m_h <= int'(b[15:0]));
    endfunction

    task automatic model_update();
        int nh, nhl, half;
        bit rs, relock;
        if (rst) begin
            m_h = 0; m_hl = 0; m_len = 0; m_fl = 0; m_slave = 0; m_extq = 0;
            for (int i = 0; i < 4; i++) m_win[i] = '0;
            for (int k = 0; k < NS; k++) begin
                m_vsq[k] = 0;
                for (int n = 0; n < 5; n++) m_set[k][n] = '0;
            end
            return;
        end
        rs = wr_en && (wr_addr == 3) && wr_data[0];
        for (int k = 0; k < NS; k++) m_vsq[k] = rs ? 1'b0 : m_vs(k);
        nh   = (m_h + 1 >= m_len) ? 0 : m_h + 1;
        half = m_len / 2;
        nhl  = m_hl;
        if (nh == 0 || (half != 0 && nh == half))
            nhl = (m_hl + 1 >= m_fl) ? 0 : m_hl + 1;
        relock = m_slave && ext_sync && !m_extq;
        m_extq = ext_sync;
        if (rs || relock) begin nh = 0; nhl = 0; end
        m_h = nh; m_hl = nhl;
        if (wr_en) begin
            if (wr_addr < 8) begin
                case (int'(wr_addr))
                    0: m_slave = wr_data[0];
                    1: m_len   = int'(wr_data[15:0]);
                    2: m_fl    = int'(wr_data[15:0]);
                    4, 5, 6, 7: m_win[int'(wr_addr) - 4] = wr_data;
                    default: ;
                endcase
            end else begin
                int s = (int'(wr_addr) - 8) / 8;
                int n = (int'(wr_addr) - 8) % 8;
                if (s < NS && n < 5) m_set[s][n] = wr_data;
            end
        end
    endtask

    // Per-cycle comparison of every output against the model.
    initial begin
        forever begin
            @(posedge clk);
            model_update();
            #1;
            if (!done) begin
                chk("R1 pixel position", int'(pix_x), m_h);
                chk("R2 line number", int'(line_y), m_line());
                chk("R2 field flag", int'(bottom_field), int'(m_bot()));
                chk("R3 active window", int'(active), int'(m_active()));
                chk("R4 top pulse", int'(top_pulse), int'(m_hl == 0 && m_h == 0));
                chk("R4 bottom pulse", int'(bottom_pulse),
                    int'(m_hl == m_fl / 2 && (m_h == 0 || m_h == m_len / 2)));
                for (int k = 0; k < NS; k++) begin
                    chk("R5 hsync", int'(hsync[k]), int'(m_hs(k)));
                    chk("R6 vsync", int'(vsync[k]), int'(m_vsq[k]) == 0 && !m_vs(k) ? 0 : int'(m_vs(k)));
                end
            end
        end
    end

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    endtask

    task automatic idle(int n);
        @(negedge clk);
        wr_en = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic load_sets();
        wr(8,  {16'd5, 16'd2});   wr(9,  {16'd2, 16'd1});  wr(10, {16'd6, 16'd5});
        wr(11, {16'd0, 16'd0});   wr(12, {16'd10, 16'd4});
        wr(16, {16'd3, 16'd17});  wr(17, {16'd3, 16'd2});  wr(18, {16'd8, 16'd7});
        wr(19, {16'd19, 16'd7});  wr(20, {16'd0, 16'd19});
        wr(24, {16'd7, 16'd7});   wr(25, {16'd1, 16'd1});  wr(26, {16'd1, 16'd8});
        wr(27, {16'd5, 16'd5});   wr(28, {16'd2, 16'd6});
        wr(32, {16'd19, 16'd0});  wr(33, {16'd4, 16'd4});  wr(34, {16'd0, 16'd0});
        wr(35, {16'd12, 16'd3});  wr(36, {16'd0, 16'd0});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        chk("R9 reset pixel", int'(pix_x), 0);
        chk("R9 reset line", int'(line_y), 1);
        chk("R9 reset hsync", int'(hsync), 0);
        chk("R9 reset vsync", int'(vsync), 0);

        // 20-pixel lines, 16 half-lines: bottom field opens at line 5, pixel 0
        wr(1, 32'd20); wr(2, 32'd16);
        wr(4, {16'd2, 16'd3}); wr(5, {16'd3, 16'd15});
        wr(6, {16'd6, 16'd0}); wr(7, {16'd8, 16'd19});
        load_sets();
        wr(3, 32'd1);
        idle(0);
        #1 chk("R7 restart pixel", int'(pix_x), 0);
        chk("R7 restart line", int'(line_y), 1);
        idle(340);

        // 14 half-lines: odd half field, bottom field opens mid-line
        wr(2, 32'd14);
        wr(3, 32'd1);
        idle(300);

        // restart register written with bit 0 clear must be ignored
        wr(3, 32'd2);
        idle(0);
        #1 chk("R7 restart bit0 clear ignored", int'(pix_x), m_h);
        idle(60);

        // master mode: external edges have no effect
        ext_sync = 1'b1;
        @(posedge clk); #1;
        chk("R8 master ignores ext_sync", int'(pix_x), m_h);
        idle(5); ext_sync = 1'b0; idle(30);

        // locked mode: rising edges relock the raster
        wr(0, 32'd1);
        idle(47);
        ext_sync = 1'b1;
        @(posedge clk); #1;
        chk("R8 relock pixel", int'(pix_x), 0);
        chk("R8 relock line", int'(line_y), 1);
        idle(12); ext_sync = 1'b0; idle(83);
        ext_sync = 1'b1; idle(150); ext_sync = 1'b0; idle(20);

        // odd 3-pixel line, 6 half-lines
        wr(0, 32'd0); wr(1, 32'd3); wr(2, 32'd6);
        wr(4, {16'd1, 16'd0}); wr(5, {16'd1, 16'd2});
        wr(6, {16'd3, 16'd1}); wr(7, {16'd3, 16'd1});
        wr(3, 32'd1);
        idle(80);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog act=timeout exp=complete");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule